// File: doc/BRIEF.md
# Output Protection and Power-Good Supervisor

This block is the digital supervisor of a synchronous buck regulator. It watches the flags produced by analog window comparators on the feedback node: above 90 % of target, below 70 %, above 125 %. It also watches an over-temperature flag, a soft-start-done flag and the combined enable and supply-good state. From these it drives the power-good output and latches the under-voltage and over-voltage faults. It also sends drive commands to the switching logic: turn both switches off, force the low-side switch on, discharge the output, and restart soft-start.

Every fault condition has its own filter, measured in clock cycles. Power-good rises only after the output has been inside the window for a full qualification delay. It drops in the same cycle that a window flag trips. Under-voltage and over-voltage faults latch and stay latched until enable drops or a supply reset occurs. Over-temperature stops switching only while the flag is high. When the flag clears, the block asks for a fresh soft-start. A two-bit status reports which latched fault came first.

Top module: `pgs_supervisor`

## Requirements
- R1: `pgood` rises only after PG_DLY consecutive clock edges at which the block is active, `ss_done`=1, `fb_hi90`=1, `fb_lo70`=0, `fb_hi125`=0, `ot_hot`=0 and no fault is latched. Any break in that run restarts the count from zero.
- R2: `pgood` drops combinationally, in the same cycle, whenever `fb_lo70`, `fb_hi125` or `ot_hot` is 1.
- R3: An under-voltage fault latches only after `fb_lo70` is sampled high on UV_DEB consecutive edges, and a shorter pulse restarts the count. Once latched, the block drives `drv_both_off`=1 and `softstop_req`=1, and if no fault was latched before, it sets `fault_code`=2'b01.
- R4: `fb_lo70` has no effect while `ss_done`=0 or while `ot_hot`=1.
- R5: An over-voltage fault latches after `fb_hi125` is sampled high on OV_FILT consecutive edges, including during soft-start. Once latched, the block drives `drv_ls_on`=1 and `softstop_req`=1, and if no fault was latched before, it sets `fault_code`=2'b10.
- R6: Fault latches and `fault_code` hold until `en_run` or `supply_ok` is low at a clock edge. At that edge they clear to zero (`fault_code`=2'b00). While the block is inactive, `drv_both_off`=1, `drv_ls_on`=0 and `softstop_req`=1 at once.
- R7: `fault_code` records only the first fault to latch. A later fault does not change it.
- R8: A latched over-voltage takes priority in the drive commands: `drv_ls_on`=1 with `drv_both_off`=0. When both faults qualify at the same edge, `fault_code`=2'b10.
- R9: `ot_hot`=1 gives `drv_both_off`=1 and `softstop_req`=1 at once and latches nothing. In the first cycle after `ot_hot` falls, `ss_rearm` is 1 for exactly one cycle.
- R10: During reset the outputs are `pgood`=0, `fault_code`=0, `drv_both_off`=1, `drv_ls_on`=0, `softstop_req`=1, `ss_rearm`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_run | input | 1 | Enable; low means shutdown |
| supply_ok | input | 1 | Bias supplies above their reset thresholds |
| ss_done | input | 1 | Soft-start ramp has finished |
| fb_hi90 | input | 1 | Feedback above 90 % of target |
| fb_lo70 | input | 1 | Feedback below 70 % of target |
| fb_hi125 | input | 1 | Feedback above 125 % of target |
| ot_hot | input | 1 | Die over-temperature flag (hysteresis applied upstream) |
| pgood | output | 1 | Power-good, high means in regulation |
| fault_code | output | 2 | First latched fault: 00 none, 01 under-voltage, 10 over-voltage |
| drv_both_off | output | 1 | Command: hold both switches off |
| drv_ls_on | output | 1 | Command: hold the low-side switch on |
| softstop_req | output | 1 | Command: discharge the output |
| ss_rearm | output | 1 | One-cycle request for a new soft-start |

## Verification
The hardest case to reach is an under-voltage and an over-voltage qualifying at the very same edge, because the two filters have different lengths. The stimulus raises the low flag first and the high flag exactly UV_DEB−OV_FILT cycles later, so both counters reach their limits together. A second difficult case is a low-voltage condition that lasts through an over-temperature episode. It is held for longer than the debounce while `ot_hot` is high, and the outputs show that nothing latched.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

  typedef enum logic [1:0] {
    FC_NONE = 2'b00,
    FC_UV   = 2'b01,
    FC_OV   = 2'b10
  } fault_code_t;

endpackage

// File: rtl/pgs_debounce.sv
// Consecutive-sample filter: hit is high when flag has been sampled
// high on LEN consecutive edges including the coming one.
module pgs_debounce #(
  parameter int unsigned LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic flag,
  output logic hit
);
  localparam int unsigned CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clr || !flag) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (cnt_q != LAST) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign hit = flag && !clr && (cnt_q == LAST);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);                                   // R3

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !flag |=> cnt_q == '0);                           // R3
endmodule

// File: rtl/pgs_fault_core.sv
module pgs_fault_core
  import pgs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        active,
  input  logic        uv_hit,
  input  logic        ov_hit,
  output logic        uv_lat,
  output logic        ov_lat,
  output fault_code_t code
);
  logic        uv_d, ov_d;
  fault_code_t code_d;

  always_comb begin
    uv_d   = uv_lat;
    ov_d   = ov_lat;
    code_d = code;
    if (!active) begin
      uv_d   = 1'b0;
      ov_d   = 1'b0;
      code_d = FC_NONE;
    end else begin
      if (uv_hit) uv_d = 1'b1;
      if (ov_hit) ov_d = 1'b1;
      if (code == FC_NONE) begin
        if (ov_hit)      code_d = FC_OV;
        else if (uv_hit) code_d = FC_UV;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_lat <= 1'b0;
      ov_lat <= 1'b0;
      code   <= FC_NONE;
    end else begin
      uv_lat <= uv_d;
      ov_lat <= ov_d;
      code   <= code_d;
    end
  end

  AST_CODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (code != FC_NONE && active) |=> $stable(code));   // R7

  AST_OV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_lat && active) |=> ov_lat);                   // R6

  AST_UV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_lat && active) |=> uv_lat);                   // R6

  AST_CLEAR_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (code == FC_NONE && !uv_lat && !ov_lat)); // R6
endmodule

// File: rtl/pgs_drive.sv
module pgs_drive (
  input  logic active,
  input  logic uv_lat,
  input  logic ov_lat,
  input  logic ot_hot,
  output logic both_off,
  output logic ls_on,
  output logic softstop
);
  always_comb begin
    both_off = 1'b0;
    ls_on    = 1'b0;
    softstop = 1'b0;
    if (!active) begin
      both_off = 1'b1;
      softstop = 1'b1;
    end else if (ov_lat) begin
      ls_on    = 1'b1;
      softstop = 1'b1;
    end else if (uv_lat || ot_hot) begin
      both_off = 1'b1;
      softstop = 1'b1;
    end
  end

  always_comb begin
    AST_DRIVE_EXCL: assert (!(ls_on && both_off));    // R8
  end
endmodule

// File: rtl/pgs_supervisor.sv
module pgs_supervisor
  import pgs_pkg::*;
#(
  parameter int unsigned PG_DLY  = 12600,
  parameter int unsigned UV_DEB  = 3200,
  parameter int unsigned OV_FILT = 300
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_run,
  input  logic       supply_ok,
  input  logic       ss_done,
  input  logic       fb_hi90,
  input  logic       fb_lo70,
  input  logic       fb_hi125,
  input  logic       ot_hot,
  output logic       pgood,
  output logic [1:0] fault_code,
  output logic       drv_both_off,
  output logic       drv_ls_on,
  output logic       softstop_req,
  output logic       ss_rearm
);
  logic        active;
  logic        uv_flag, uv_hit, ov_hit, pg_hit;
  logic        uv_lat, ov_lat;
  logic        pg_cond;
  logic        pg_q, pg_d, pg_en;
  logic        ot_q;
  fault_code_t code;

  assign active  = en_run && supply_ok;
  assign uv_flag = fb_lo70 && ss_done && !ot_hot;
  assign pg_cond = active && ss_done && fb_hi90 && !fb_lo70 && !fb_hi125 &&
                   !ot_hot && !uv_lat && !ov_lat;

  pgs_debounce #(.LEN(UV_DEB)) u_uv_flt (
    .clk(clk), .rst_n(rst_n), .clr(!active), .flag(uv_flag), .hit(uv_hit));

  pgs_debounce #(.LEN(OV_FILT)) u_ov_flt (
    .clk(clk), .rst_n(rst_n), .clr(!active), .flag(fb_hi125), .hit(ov_hit));

  pgs_debounce #(.LEN(PG_DLY)) u_pg_dly (
    .clk(clk), .rst_n(rst_n), .clr(!active), .flag(pg_cond), .hit(pg_hit));

  pgs_fault_core u_core (
    .clk(clk), .rst_n(rst_n), .active(active),
    .uv_hit(uv_hit), .ov_hit(ov_hit),
    .uv_lat(uv_lat), .ov_lat(ov_lat), .code(code));

  pgs_drive u_drive (
    .active(active), .uv_lat(uv_lat), .ov_lat(ov_lat), .ot_hot(ot_hot),
    .both_off(drv_both_off), .ls_on(drv_ls_on), .softstop(softstop_req));

  always_comb begin
    pg_d  = pg_q;
    pg_en = 1'b0;
    if (!pg_cond) begin
      pg_d  = 1'b0;
      pg_en = pg_q;
    end else if (pg_hit) begin
      pg_d  = 1'b1;
      pg_en = !pg_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q <= 1'b0;
      ot_q <= 1'b0;
    end else begin
      if (pg_en) pg_q <= pg_d;
      ot_q <= ot_hot;
    end
  end

  assign pgood      = pg_q && !fb_lo70 && !fb_hi125 && !ot_hot && !uv_lat && !ov_lat;
  assign ss_rearm   = active && ot_q && !ot_hot;
  assign fault_code = code;

  AST_PG_NEEDS_SS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_q) |-> $past(ss_done && fb_hi90));       // R1

  AST_UV_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uv_lat) |-> $past(ss_done && !ot_hot && fb_lo70)); // R4

  AST_OT_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_hot && !fb_hi125 && code == FC_NONE && active) |=> code == FC_NONE); // R9

  AST_REARM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ss_rearm |=> !ss_rearm);                          // R9
endmodule

// File: tb/pgs_supervisor_test.sv
`timescale 1ns/1ps
module pgs_supervisor_test;
  localparam int PG = 8;
  localparam int UV = 5;
  localparam int OV = 3;

  logic clk = 1'b0;
  logic rst_n, en_run, supply_ok, ss_done, fb_hi90, fb_lo70, fb_hi125, ot_hot;
  logic pgood, drv_both_off, drv_ls_on, softstop_req, ss_rearm;
  logic [1:0] fault_code;

  always #2.5 clk = ~clk;

  pgs_supervisor #(.PG_DLY(PG), .UV_DEB(UV), .OV_FILT(OV)) uut (
    .clk(clk), .rst_n(rst_n), .en_run(en_run), .supply_ok(supply_ok),
    .ss_done(ss_done), .fb_hi90(fb_hi90), .fb_lo70(fb_lo70),
    .fb_hi125(fb_hi125), .ot_hot(ot_hot), .pgood(pgood),
    .fault_code(fault_code), .drv_both_off(drv_both_off),
    .drv_ls_on(drv_ls_on), .softstop_req(softstop_req), .ss_rearm(ss_rearm));

  typedef struct {
    string      tag;
    logic [6:0] exp;
  } item_t;

  item_t q[$];
  event  sample_ev;
  int    n_chk = 0;
  int    n_err = 0;
  bit    done  = 1'b0;

  function automatic logic [6:0] v(bit pg, bit [1:0] c, bit off, bit ls, bit ss, bit rm);
    return {pg, c, off, ls, ss, rm};
  endfunction

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      @(sample_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [6:0] act;
        it  = q.pop_front();
        act = {pgood, fault_code, drv_both_off, drv_ls_on, softstop_req, ss_rearm};
        n_chk++;
        if (act !== it.exp) begin
          n_err++;
          $display("FAIL %s: {pg,code,off,ls,ss,rearm} actual=%b expected=%b",
                   it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [6:0] e);
    item_t it;
    #0.5;
    it.tag = tag;
    it.exp = e;
    q.push_back(it);
    ->sample_ev;
    #0.5;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; en_run = 0; supply_ok = 0; ss_done = 0;
    fb_hi90 = 0; fb_lo70 = 0; fb_hi125 = 0; ot_hot = 0;
    tick(2);
    chk("R10 reset", v(0, 0, 1, 0, 1, 0));
    rst_n = 1; en_run = 1; supply_ok = 1;
    tick(2);
    chk("R10 active idle", v(0, 0, 0, 0, 0, 0));

    // R1 power-good delay
    ss_done = 1; fb_hi90 = 1;
    tick(PG - 1);
    chk("R1 before delay", v(0, 0, 0, 0, 0, 0));
    tick(1);
    chk("R1 after delay", v(1, 0, 0, 0, 0, 0));

    // R2 immediate drop, R3 debounce restart
    fb_lo70 = 1;
    chk("R2 uv drop", v(0, 0, 0, 0, 0, 0));
    tick(UV - 1);
    chk("R3 short pulse", v(0, 0, 0, 0, 0, 0));
    fb_lo70 = 0;
    tick(1);
    chk("R3 no latch", v(0, 0, 0, 0, 0, 0));
    fb_lo70 = 1;
    tick(UV - 1);
    fb_lo70 = 0;
    tick(1);
    chk("R3 restart", v(0, 0, 0, 0, 0, 0));
    fb_lo70 = 1;
    tick(UV - 1);
    chk("R3 pre-latch", v(0, 0, 0, 0, 0, 0));
    tick(1);
    chk("R3 uv latched", v(0, 1, 1, 0, 1, 0));
    fb_lo70 = 0;
    tick(3);
    chk("R6 uv held", v(0, 1, 1, 0, 1, 0));

    // R7/R8 later over-voltage
    fb_hi125 = 1;
    tick(OV - 1);
    chk("R5 ov pending", v(0, 1, 1, 0, 1, 0));
    tick(1);
    chk("R8 ov priority R7 first code", v(0, 1, 0, 1, 1, 0));
    fb_hi125 = 0; en_run = 0;
    chk("R6 inactive at once", v(0, 1, 1, 0, 1, 0));
    tick(1);
    chk("R6 cleared", v(0, 0, 1, 0, 1, 0));
    en_run = 1; ss_done = 0; fb_hi90 = 0;
    tick(1);
    chk("R6 re-enabled", v(0, 0, 0, 0, 0, 0));

    // R4 uv ignored during soft-start
    fb_lo70 = 1;
    tick(3 * UV);
    chk("R4 uv blocked in soft-start", v(0, 0, 0, 0, 0, 0));
    fb_lo70 = 0;

    // R5 ov during soft-start, with filter restart
    fb_hi125 = 1;
    tick(OV - 1);
    fb_hi125 = 0;
    tick(1);
    chk("R5 ov short pulse", v(0, 0, 0, 0, 0, 0));
    fb_hi125 = 1;
    tick(OV - 1);
    chk("R5 ov pending", v(0, 0, 0, 0, 0, 0));
    tick(1);
    chk("R5 ov latched", v(0, 2, 0, 1, 1, 0));
    fb_hi125 = 0;
    supply_ok = 0;
    tick(1);
    chk("R6 supply reset clears", v(0, 0, 1, 0, 1, 0));
    supply_ok = 1;
    tick(1);
    chk("R6 supply back", v(0, 0, 0, 0, 0, 0));

    // R8 simultaneous qualification
    ss_done = 1;
    fb_lo70 = 1;
    tick(UV - OV);
    fb_hi125 = 1;
    tick(OV - 1);
    chk("R8 both pending", v(0, 0, 0, 0, 0, 0));
    tick(1);
    chk("R8 same edge", v(0, 2, 0, 1, 1, 0));
    fb_lo70 = 0; fb_hi125 = 0; en_run = 0;
    tick(1);
    en_run = 1;
    tick(1);
    chk("R6 cleared again", v(0, 0, 0, 0, 0, 0));

    // R9 over-temperature
    fb_hi90 = 1;
    tick(PG);
    chk("R1 pgood again", v(1, 0, 0, 0, 0, 0));
    ot_hot = 1;
    chk("R9 ot at once R2", v(0, 0, 1, 0, 1, 0));
    fb_lo70 = 1;
    tick(2 * UV);
    chk("R4 uv blocked in ot", v(0, 0, 1, 0, 1, 0));
    fb_lo70 = 0;
    tick(1);
    ot_hot = 0;
    chk("R9 rearm pulse", v(0, 0, 0, 0, 0, 1));
    tick(1);
    chk("R9 rearm ends", v(0, 0, 0, 0, 0, 0));
    tick(PG - 2);
    chk("R1 redelay pending", v(0, 0, 0, 0, 0, 0));
    tick(1);
    chk("R1 redelay done", v(1, 0, 0, 0, 0, 0));

    done = 1'b1;
    #1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule